// File: doc/BRIEF.md
# Packet-Tagged HDLC Receive FIFO

This block sits between the byte output of an HDLC receiver and a microprocessor read port. It holds up to 128 received bytes. Each entry carries a ninth bit, written alongside the data, that marks the byte as the final one of a packet. A packet can end with a closing flag, an abort, or an invalid frame.

The block reports four single-cycle events. One fires when a packet-ending byte is stored. One fires when the entry now waiting at the head is a packet end, so software knows that its next read finishes a packet. One fires when the fill level climbs past a programmable threshold. One fires when a write arrives at a completely full FIFO. An overflow turns the receive path off, and every write after it is dropped. The next detected flag turns the path back on. If software has not drained the FIFO by then, the next write overflows again.

All outputs are registered. Every event appears in the cycle after the clock edge that caused it.

Top module: `rx_pkt_fifo`

## Requirements
- R1: The FIFO holds exactly 128 entries. After reset, 128 writes are all stored and later read back in write order. The occupancy never exceeds 128.
- R2: A write enabled while 128 entries are occupied is an overflow. The occupancy is taken at the start of the cycle, even if a read happens in the same cycle. The byte is not stored. `ovflEvt` is 1 for the one cycle after that edge, and `rxEnabled` is 0 from that edge on.
- R3: While `rxEnabled` is 0, `flagSeen` high at an edge sets `rxEnabled` to 1 after that edge. If the FIFO is still full, the next write overflows again.
- R4: An accepted write with `wrLast`=1 makes `eopWrEvt` 1 for the one cycle after its edge. Writes with `wrLast`=0 do not raise it.
- R5: `eopReadEvt` is 1 for one cycle after an edge at which a byte tagged as a packet end becomes the head entry. This happens either when a read exposes the byte or when the byte is written into an empty FIFO.
- R6: A read of an empty FIFO also makes `eopReadEvt` 1 for one cycle. `rdData` keeps its previous value.
- R7: `fullEvt` is 1 for the one cycle after an edge at which the occupancy goes from at most `fullThresh` to above it. It is not repeated while the occupancy stays above the threshold.
- R8: A write while `rxEnabled` is 0 is discarded. It changes no stored entry and raises neither `eopWrEvt` nor `ovflEvt`.
- R9: A read of a non-empty FIFO puts the head byte on `rdData` after the read edge and removes that byte.
- R10: After reset, the FIFO is empty, `rxEnabled` is 1, `rdData` is 0 and all four events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Receiver write strobe |
| wrData | input | 8 | Received byte |
| wrLast | input | 1 | Marks the byte as the end of a packet |
| flagSeen | input | 1 | Flag-detected strobe from the receiver |
| rdEn | input | 1 | Processor read strobe |
| fullThresh | input | 8 | Fill level that the full event must exceed |
| rdData | output | 8 | Last byte read |
| rxEnabled | output | 1 | Receive path enabled |
| ovflEvt | output | 1 | Overflow event |
| eopWrEvt | output | 1 | Packet-end byte stored |
| eopReadEvt | output | 1 | Packet end at head, or read of an empty FIFO |
| fullEvt | output | 1 | Fill level crossed the threshold |

## Verification
The assertions check, on every cycle:
- the occupancy bound;
- that an overflow only follows a full FIFO, always leaves the receiver off, and never repeats back to back;
- that the receiver stays off until a flag arrives;
- that disabled writes leave the occupancy unchanged;
- that each full event matches a real upward crossing.

Only the bench scenarios can show the rest:
- the data order across a full 128-entry pass;
- the exact write at which the threshold event fires, for several thresholds;
- which reads expose a tagged head byte;
- the repeat overflow after a flag on a still-full FIFO.

// File: rtl/rx_pkt_fifo_pkg.sv
package rx_pkt_fifo_pkg;
  // Strobes from the control to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/rx_pkt_fifo_ctrl.sv
module rx_pkt_fifo_ctrl
  import rx_pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrLast,
  input  logic             rdEn,
  input  logic             flagSeen,
  input  logic [CNT_W-1:0] fullThresh,
  input  logic             headLastNext,
  output fifoStrobe_t      st,
  output logic [CNT_W-1:0] fillCount,
  output logic             rxEnabled,
  output logic             ovflEvt,
  output logic             eopWrEvt,
  output logic             eopReadEvt,
  output logic             fullEvt
);
  localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(DEPTH);

  logic isFull, isEmpty, accept, overflow, emptyRead, headArrive;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    isFull    = (fillCount == FULL_LEVEL);
    isEmpty   = (fillCount == '0);
    accept    = wrEn && rxEnabled;
    overflow  = accept && isFull;
    emptyRead = rdEn && isEmpty;
    st.push   = accept && !isFull;
    st.pop    = rdEn && !isEmpty;
    countNext = fillCount + CNT_W'(st.push) - CNT_W'(st.pop);
    // The head entry changes when a read exposes a new entry or a write lands in an empty FIFO
    headArrive = (st.pop && (countNext != '0)) || (st.push && isEmpty);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount  <= '0;
      rxEnabled  <= 1'b1;
      ovflEvt    <= 1'b0;
      eopWrEvt   <= 1'b0;
      eopReadEvt <= 1'b0;
      fullEvt    <= 1'b0;
    end else begin
      fillCount  <= countNext;
      if (overflow) rxEnabled <= 1'b0;
      else if (!rxEnabled && flagSeen) rxEnabled <= 1'b1;
      ovflEvt    <= overflow;
      eopWrEvt   <= st.push && wrLast;
      eopReadEvt <= emptyRead || (headArrive && headLastNext);
      fullEvt    <= (fillCount <= fullThresh) && (countNext > fullThresh);
    end
  end
endmodule

// File: rtl/rx_pkt_fifo_dp.sv
module rx_pkt_fifo_dp
  import rx_pkt_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic [DATA_W-1:0] rdData,
  output logic              headLastNext
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  tagMem;
  logic [PTR_W-1:0]  wPtr, rPtr, headIdx;

  always_comb begin
    headIdx = st.pop ? rPtr + PTR_W'(1) : rPtr;
    // Bypass: the new head may be the entry written in this same cycle
    headLastNext = (st.push && (headIdx == wPtr)) ? wrLast : tagMem[headIdx];
  end

  always_ff @(posedge clk) begin
    if (st.push) begin
      dataMem[wPtr] <= wrData;
      tagMem[wPtr]  <= wrLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr   <= '0;
      rPtr   <= '0;
      rdData <= '0;
    end else begin
      if (st.push) wPtr <= wPtr + PTR_W'(1);
      if (st.pop) begin
        rPtr   <= rPtr + PTR_W'(1);
        rdData <= dataMem[rPtr];
      end
    end
  end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_pkt_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic              flagSeen,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  fullThresh,
  output logic [DATA_W-1:0] rdData,
  output logic              rxEnabled,
  output logic              ovflEvt,
  output logic              eopWrEvt,
  output logic              eopReadEvt,
  output logic              fullEvt
);
  fifoStrobe_t      st;
  logic [CNT_W-1:0] fillCount;
  logic             headLastNext;

  rx_pkt_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLast(wrLast), .rdEn(rdEn),
    .flagSeen(flagSeen), .fullThresh(fullThresh), .headLastNext(headLastNext),
    .st(st), .fillCount(fillCount), .rxEnabled(rxEnabled), .ovflEvt(ovflEvt),
    .eopWrEvt(eopWrEvt), .eopReadEvt(eopReadEvt), .fullEvt(fullEvt)
  );

  rx_pkt_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .wrLast(wrLast),
    .rdData(rdData), .headLastNext(headLastNext)
  );
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrLast,
  input logic             rdEn,
  input logic             flagSeen,
  input logic [CNT_W-1:0] fullThresh,
  input logic [CNT_W-1:0] fillCount,
  input logic             rxEnabled,
  input logic             ovflEvt,
  input logic             eopWrEvt,
  input logic             fullEvt
);
  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH)); // R1
  AST_OVFL_FROM_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ovflEvt |-> ($past(fillCount) == CNT_W'(DEPTH))); // R2
  AST_OVFL_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    ovflEvt |-> !rxEnabled); // R2
  AST_OVFL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ovflEvt |=> !ovflEvt); // R2
  AST_FLAG_REENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnabled && flagSeen) |=> rxEnabled); // R3
  AST_STAYS_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnabled && !flagSeen) |=> !rxEnabled); // R3
  AST_EOPW_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    eopWrEvt |-> $past(wrEn && wrLast && rxEnabled)); // R4
  AST_FULL_CROSSING: assert property (@(posedge clk) disable iff (!rstN)
    fullEvt |-> ((fillCount > fullThresh) && ($past(fillCount) <= $past(fullThresh)))); // R7
  AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnabled && wrEn && !rdEn) |=> $stable(fillCount)); // R8
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLast(wrLast), .rdEn(rdEn),
  .flagSeen(flagSeen), .fullThresh(fullThresh), .fillCount(fillCount),
  .rxEnabled(rxEnabled), .ovflEvt(ovflEvt), .eopWrEvt(eopWrEvt), .fullEvt(fullEvt)
);

// File: tb/rx_pkt_fifo_tb.sv
module rx_pkt_fifo_tb;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, wrLast = 1'b0, flagSeen = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] fullThresh = '0;
  logic [7:0] rdData;
  logic       rxEnabled, ovflEvt, eopWrEvt, eopReadEvt, fullEvt;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_pkt_fifo u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrLast(wrLast),
    .flagSeen(flagSeen), .rdEn(rdEn), .fullThresh(fullThresh), .rdData(rdData),
    .rxEnabled(rxEnabled), .ovflEvt(ovflEvt), .eopWrEvt(eopWrEvt),
    .eopReadEvt(eopReadEvt), .fullEvt(fullEvt)
  );

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply inputs for one edge, then leave the sampling point 1 ns after it
  task automatic step(input logic w, input logic [7:0] d, input logic l,
                      input logic r, input logic f);
    wrEn = w; wrData = d; wrLast = l; rdEn = r; flagSeen = f;
    @(posedge clk); #1;
    wrEn = 1'b0; wrLast = 1'b0; rdEn = 1'b0; flagSeen = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  function automatic bit tagOf(input int i);
    return (i % 5) == 4;
  endfunction

  initial begin
    int ths[5] = '{0, 1, 64, 127, 128};
    doReset();
    // R10 reset state
    check("R10 rxEnabled", rxEnabled, 1);
    check("R10 rdData", rdData, 0);
    check("R10 events", {ovflEvt, eopWrEvt, eopReadEvt, fullEvt}, 0);

    foreach (ths[t]) begin
      doReset();
      fullThresh = 8'(ths[t]);
      for (int i = 0; i < DEPTH; i++) begin
        step(1'b1, 8'(i), tagOf(i), 1'b0, 1'b0);
        check("R7 fullEvt", fullEvt, (i == ths[t]) ? 1 : 0);
        check("R4 eopWrEvt", eopWrEvt, tagOf(i) ? 1 : 0);
        check("R1 no early overflow", ovflEvt, 0);
      end
      // R2 write into full FIFO
      step(1'b1, 8'hEE, 1'b1, 1'b0, 1'b0);
      check("R2 ovflEvt", ovflEvt, 1);
      check("R2 rxEnabled off", rxEnabled, 0);
      check("R2 no eopWrEvt", eopWrEvt, 0);
      check("R7 no repeat", fullEvt, 0);
    end

    // R8 disabled write dropped
    step(1'b1, 8'h5A, 1'b1, 1'b0, 1'b0);
    check("R8 eopWrEvt", eopWrEvt, 0);
    check("R8 ovflEvt", ovflEvt, 0);
    check("R8 still disabled", rxEnabled, 0);
    // R3 flag re-enables, next write overflows again
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R3 re-enabled", rxEnabled, 1);
    step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0);
    check("R3 overflow again", ovflEvt, 1);
    check("R3 disabled again", rxEnabled, 0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R3 re-enabled twice", rxEnabled, 1);

    // R9 / R5 / R1 drain all 128 entries
    for (int k = 0; k < DEPTH; k++) begin
      step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      check("R9 rdData order", rdData, k);
      check("R5 eopReadEvt on read", eopReadEvt, ((k + 1 < DEPTH) && tagOf(k + 1)) ? 1 : 0);
    end
    // R6 empty read
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R6 eopReadEvt empty", eopReadEvt, 1);
    check("R6 rdData held", rdData, DEPTH - 1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 single pulse", eopReadEvt, 0);
    // R5 tagged byte into empty FIFO
    step(1'b1, 8'hA5, 1'b1, 1'b0, 1'b0);
    check("R5 head arrives tagged", eopReadEvt, 1);
    check("R4 eopWrEvt tagged", eopWrEvt, 1);
    step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0);
    check("R5 no event untagged second", eopReadEvt, 0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9 rdData A5", rdData, 8'hA5);
    check("R5 untagged head", eopReadEvt, 0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9 rdData 3C", rdData, 8'h3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule